// File: doc/BRIEF.md
# Multiple-register transfer address sequencer

This block drives a block transfer between a register file and memory. A caller presents a register-selection mask, a base byte address and four controls: adjust-before or adjust-after, count up or count down, write the final address back, and load or store. One cycle later the block starts issuing one access per cycle. Each access carries the register index and the word address to use. Once the last access is out, a one-cycle completion pulse carries the new base value to write back.

Registers are always visited in ascending index order, and ascending addresses go with them. The lowest selected register therefore lands at the lowest address whatever the count direction. The count direction only moves the window of addresses relative to the base. A stack mode input maps the four stack kinds onto the same before/after and up/down controls. The four kinds are pointer-at-last-used or pointer-at-next-free, each growing upward or downward. Push is a store and pop is a load.

Top module: `ldm_seq`

## Requirements
- R1: Every register i whose mask bit i is set gets exactly one access, and accesses go in strictly ascending index order on `acc_reg`.
- R2: The first access has the lowest address. Each later access is exactly 4 bytes above the one before it.
- R3: With n selected registers and base B, the first address is B (up, after), B+4 (up, before), B-4n+4 (down, after) or B-4n (down, before).
- R4: In the completion cycle, `wb_valid` equals the write-back control latched at start, and `wb_base` is B+4n when counting up or B-4n when counting down. `wb_valid` is never high outside a completion cycle.
- R5: `acc_load` equals the load control latched at start (1 = load, 0 = store) for every access of the transfer.
- R6: When `stk_en` is 1, `pre` and `up` are ignored. A push (load=0) uses before = `stk_full` and up = `stk_asc`. A pop (load=1) uses before = not `stk_full` and up = not `stk_asc`.
- R7: A start with an all-zero mask raises `err` for exactly one cycle, the cycle after start. It makes no access and gives no completion pulse.
- R8: `busy` is high from the cycle after start through the cycle of the last access, n cycles in total. `done` is high for exactly the one cycle after that.
- R9: A start that arrives while `busy` is high is ignored, and the running transfer's registers and addresses go on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer when idle |
| reglist | input | NREG | Register-selection mask |
| base | input | AW | Base byte address |
| pre | input | 1 | 1 = adjust before each access, 0 = after |
| up | input | 1 | 1 = count up, 0 = count down |
| wb | input | 1 | Report the final address for write-back |
| load | input | 1 | 1 = load from memory, 0 = store |
| stk_en | input | 1 | Use the stack-kind inputs instead of pre/up |
| stk_full | input | 1 | Stack pointer points at the last used word |
| stk_asc | input | 1 | Stack grows toward higher addresses |
| busy | output | 1 | An access is presented this cycle |
| acc_reg | output | $clog2(NREG) | Register index of the current access |
| acc_addr | output | AW | Byte address of the current access |
| acc_load | output | 1 | Direction of the current access |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle empty-mask error pulse |
| wb_valid | output | 1 | Write-back value valid (with done) |
| wb_base | output | AW | New base value |

## Verification
The bench goes after the four address windows and the four stack kinds, for both push and pop. A design that mixed up before and after would be off by one word at both ends of the window. A design that ordered registers by count direction would reverse the register-to-address pairing on downward transfers. Single-register masks, the full 16-register mask and masks with only bit 15 set test the last-access detection: an off-by-one there stretches or shortens `busy`, or moves `done` by a cycle. Empty masks and starts raised in the middle of a transfer check that nothing is accessed on error and that a running transfer is never restarted.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;
   // Effective addressing controls after stack-mode mapping
   typedef struct packed {
      logic pre;
      logic up;
   } addr_ctl_t;
endpackage

// File: rtl/ldm_mode_map.sv
module ldm_mode_map
   import ldm_seq_pkg::*;
(
   input  logic      pre,
   input  logic      up,
   input  logic      load,
   input  logic      stk_en,
   input  logic      stk_full,
   input  logic      stk_asc,
   output addr_ctl_t ctl
);
   // Push mirrors the stack kind directly, pop uses the inverse
   always_comb begin
      if (stk_en) begin
         ctl.pre = stk_full ^ load;
         ctl.up  = stk_asc ^ load;
      end else begin
         ctl.pre = pre;
         ctl.up  = up;
      end
   end
endmodule

// File: rtl/ldm_addr_plan.sv
module ldm_addr_plan
   import ldm_seq_pkg::*;
#(
   parameter int NREG = 16,
   parameter int AW   = 32,
   parameter int WB   = 4
) (
   input  logic [NREG-1:0] mask,
   input  logic [AW-1:0]   base,
   input  addr_ctl_t       ctl,
   output logic [AW-1:0]   first_addr,
   output logic [AW-1:0]   final_base,
   output logic            empty
);
   localparam int CW = $clog2(NREG + 1);
   localparam int SH = $clog2(WB);

   logic [CW-1:0] cnt;
   logic [AW-1:0] span;
   logic [AW-1:0] hi;
   logic [AW-1:0] lo;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NREG; i++) cnt = cnt + CW'(mask[i]);
   end

   assign span  = AW'(cnt) << SH;
   assign hi    = base + span;
   assign lo    = base - span;
   assign empty = (cnt == '0);

   always_comb begin
      if (ctl.up) begin
         final_base = hi;
         first_addr = ctl.pre ? base + AW'(WB) : base;
      end else begin
         final_base = lo;
         first_addr = ctl.pre ? lo : lo + AW'(WB);
      end
   end
endmodule

// File: rtl/ldm_low_pick.sv
module ldm_low_pick #(
   parameter int NREG = 16,
   localparam int IW  = $clog2(NREG)
) (
   input  logic [NREG-1:0] mask,
   output logic [NREG-1:0] onehot,
   output logic [IW-1:0]   idx,
   output logic            last
);
   // below[i] : some bit under position i is set
   logic [NREG:0] below;
   assign below[0] = 1'b0;

   for (genvar i = 0; i < NREG; i++) begin : g_chain
      assign onehot[i]  = mask[i] & ~below[i];
      assign below[i+1] = below[i] | mask[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NREG; i++)
         if (onehot[i]) idx = idx | IW'(i);
   end

   assign last = ((mask & ~onehot) == '0);
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
   import ldm_seq_pkg::*;
#(
   parameter int NREG = 16,
   parameter int AW   = 32,
   parameter int WB   = 4,
   localparam int IW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NREG-1:0] reglist,
   input  logic [AW-1:0]   base,
   input  logic            pre,
   input  logic            up,
   input  logic            wb,
   input  logic            load,
   input  logic            stk_en,
   input  logic            stk_full,
   input  logic            stk_asc,
   output logic            busy,
   output logic [IW-1:0]   acc_reg,
   output logic [AW-1:0]   acc_addr,
   output logic            acc_load,
   output logic            done,
   output logic            err,
   output logic            wb_valid,
   output logic [AW-1:0]   wb_base
);
   if (NREG < 2) begin : g_bad_nreg
      $error("ldm_seq: NREG must be at least 2");
   end
   if (WB < 1 || (WB & (WB - 1)) != 0) begin : g_bad_wb
      $error("ldm_seq: WB must be a power of two");
   end
   if (AW < $clog2(NREG * WB) + 1) begin : g_bad_aw
      $error("ldm_seq: AW too small for the transfer span");
   end

   addr_ctl_t       ctl;
   logic [AW-1:0]   first_addr;
   logic [AW-1:0]   final_base;
   logic            empty;
   logic [NREG-1:0] sel_oh;
   logic [IW-1:0]   sel_idx;
   logic            sel_last;

   logic            busy_q;
   logic [NREG-1:0] mask_q;
   logic [AW-1:0]   addr_q;
   logic            load_q;
   logic            wbf_q;
   logic [AW-1:0]   wbb_q;
   logic            done_q;
   logic            err_q;

   ldm_mode_map u_map (
      .pre      (pre),
      .up       (up),
      .load     (load),
      .stk_en   (stk_en),
      .stk_full (stk_full),
      .stk_asc  (stk_asc),
      .ctl      (ctl)
   );

   ldm_addr_plan #(.NREG(NREG), .AW(AW), .WB(WB)) u_plan (
      .mask       (reglist),
      .base       (base),
      .ctl        (ctl),
      .first_addr (first_addr),
      .final_base (final_base),
      .empty      (empty)
   );

   ldm_low_pick #(.NREG(NREG)) u_pick (
      .mask   (mask_q),
      .onehot (sel_oh),
      .idx    (sel_idx),
      .last   (sel_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mask_q <= '0;
         addr_q <= '0;
         load_q <= 1'b0;
         wbf_q  <= 1'b0;
         wbb_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (busy_q) begin
            mask_q <= mask_q & ~sel_oh;
            addr_q <= addr_q + AW'(WB);
            if (sel_last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (start) begin
            if (empty) begin
               err_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               mask_q <= reglist;
               addr_q <= first_addr;
               load_q <= load;
               wbf_q  <= wb;
               wbb_q  <= final_base;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign acc_reg  = sel_idx;
   assign acc_addr = addr_q;
   assign acc_load = load_q;
   assign done     = done_q;
   assign err      = err_q;
   assign wb_valid = done_q & wbf_q;
   assign wb_base  = wbb_q;
endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk #(
   parameter int NREG = 16,
   parameter int AW   = 32,
   parameter int WB   = 4,
   localparam int IW  = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [NREG-1:0] reglist,
   input logic            busy,
   input logic [IW-1:0]   acc_reg,
   input logic [AW-1:0]   acc_addr,
   input logic            acc_load,
   input logic            done,
   input logic            err,
   input logic            wb_valid
);
   // R1
   reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> acc_reg > $past(acc_reg));
   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> acc_addr == $past(acc_addr) + AW'(WB));
   // R4
   wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);
   // R5
   dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(acc_load));
   // R7
   empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && reglist == '0 |=> err && !busy && !done);
   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));
   // R8
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err, busy}));
   // R9
   no_err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !err);
endmodule

bind ldm_seq ldm_seq_chk #(.NREG(NREG), .AW(AW), .WB(WB)) chk_i (.*);

// File: tb/ldm_seq_tb.sv
module ldm_seq_tb_top;
   localparam int NREG = 16;
   localparam int AW   = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [NREG-1:0] reglist = '0;
   logic [AW-1:0]   base = '0;
   logic            pre = 1'b0, up = 1'b0, wb = 1'b0, load = 1'b0;
   logic            stk_en = 1'b0, stk_full = 1'b0, stk_asc = 1'b0;
   logic            busy, acc_load, done, err, wb_valid;
   logic [3:0]      acc_reg;
   logic [AW-1:0]   acc_addr, wb_base;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;   // 50 MHz

   ldm_seq dut_i (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int popc(input logic [15:0] m);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(m[i]);
      return c;
   endfunction

   function automatic logic [AW-1:0] first_of(input logic [AW-1:0] b, input int n,
                                              input bit p, input bit u);
      if (u) return p ? b + 4 : b;
      return p ? b - AW'(4 * n) : b - AW'(4 * n) + 4;
   endfunction

   task automatic xact(input logic [15:0] lst, input logic [AW-1:0] b,
                       input bit p, input bit u, input bit w, input bit l,
                       input bit se, input bit sf, input bit sa, input bit noise);
      bit ep, eu;
      int n;
      logic [AW-1:0] a, fb;
      ep = se ? (l ? !sf : sf) : p;   // R6 mapping
      eu = se ? (l ? !sa : sa) : u;
      n  = popc(lst);
      a  = first_of(b, n, ep, eu);
      fb = eu ? b + AW'(4 * n) : b - AW'(4 * n);
      @(negedge clk);
      reglist = lst; base = b; pre = p; up = u; wb = w; load = l;
      stk_en = se; stk_full = sf; stk_asc = sa; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (n == 0) begin
         chk(err && !busy && !done, "R7", {err, busy, done}, 3'b100);
         @(negedge clk);
         chk(!err && !busy && !done, "R7", {err, busy, done}, 3'b000);
         return;
      end
      for (int k = 0; k < 16; k++) begin
         if (lst[k]) begin
            chk(busy && acc_reg == 4'(k), se ? "R6" : "R1", acc_reg, k);
            chk(acc_addr == a, se ? "R6" : "R3", acc_addr, a);
            chk(acc_load == l, "R5", acc_load, l);
            a = a + 4;
            if (noise) begin
               start = 1'b1; reglist = 16'hFFFF; base = '0;   // R9 mid-transfer start
            end
            @(negedge clk);
            start = 1'b0;
         end
      end
      chk(done && !busy, "R8", {done, busy}, 2'b10);
      chk(wb_valid == w, "R4", wb_valid, w);
      if (w) chk(wb_base == fb, "R4", wb_base, fb);
      @(negedge clk);
      chk(!done && !busy && !err && !wb_valid, "R8", {done, busy, err}, 3'b000);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && !wb_valid, "R8", {busy, done, err}, 3'b000);
      rst_n = 1'b1;
      // directed: the four windows, R3
      xact(16'h0F00, 32'h200, 0, 1, 1, 0, 0, 0, 0, 0);
      xact(16'h0F00, 32'h200, 1, 1, 1, 1, 0, 0, 0, 0);
      xact(16'h0F00, 32'h200, 0, 0, 1, 0, 0, 0, 0, 0);
      xact(16'h0F00, 32'h200, 1, 0, 1, 1, 0, 0, 0, 0);
      // edge masks: single low, single high, full, R8
      xact(16'h0001, 32'h1000, 1, 0, 1, 0, 0, 0, 0, 0);
      xact(16'h8000, 32'h1000, 0, 1, 0, 1, 0, 0, 0, 0);
      xact(16'hFFFF, 32'h4000, 1, 0, 1, 0, 0, 0, 0, 0);
      // R7 empty list
      xact(16'h0000, 32'h300, 1, 1, 1, 0, 0, 0, 0, 0);
      // R6 every stack kind, push then pop
      for (int s = 0; s < 4; s++) begin
         xact(16'h400F, 32'h800, 1, 1, 1, 0, 1, s[1], s[0], 0);
         xact(16'h400F, 32'h800, 0, 0, 1, 1, 1, s[1], s[0], 0);
      end
      // R9 start raised throughout a transfer
      xact(16'h00A5, 32'h600, 0, 1, 1, 0, 0, 0, 0, 1);
      // random mix
      for (int t = 0; t < 300; t++) begin
         logic [15:0] m;
         m = 16'($urandom);
         if ($urandom_range(0, 3) == 0) m = m & 16'($urandom);
         if ($urandom_range(0, 19) == 0) m = '0;
         xact(m, $urandom & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule